// File: doc/BRIEF.md
# Serialized interrupt slave transmitter

This block is the peripheral end of a one-wire, open-drain interrupt bus that runs on the bus clock. It watches the shared line. When it sees a start frame, it steps through a fixed series of three-clock data slots. In the first clock of each slot whose request bit is pending, it pulls the line low. In the second clock it drives the line high again, and in the third clock it lets go of the line.

After the last slot, the host sends a stop pulse. The block measures the width of that pulse to choose the mode of the next cycle. A two-clock pulse selects quiet mode, and any other width selects continuous mode. In continuous mode the block only answers cycles that the host begins. In quiet mode, when a request is waiting on an idle line, the block pulls the line low for a single clock. The host then completes the start frame.

The line sample comes in on `line_i`. The pad is formed from `oe_o` and `drive_low_o`: when `oe_o` is high the block drives the line, low if `drive_low_o` is set and high otherwise.

Top module: `sirq_slave`

## Requirements
- R1: After reset, `oe_o` and `drive_low_o` are low and the block is in continuous mode, so it drives nothing while the line stays idle.
- R2: While idle, a run of at least 4 consecutive low samples followed by a high sample is a start frame. The sample phase of slot 0 is the clock that follows that high sample.
- R3: A low run of fewer than 4 samples is ignored. No slot is driven afterwards.
- R4: In the first clock of slot k (k counts from 0), the block drives low if and only if `req_i[k]` is set. Otherwise `oe_o` is low. Bit 0 is IRQ0, bit 1 is IRQ1, bit 2 is SMI, bits 3 to 15 are IRQ3 to IRQ15, and bit 16 is the channel-check slot.
- R5: In the second clock of a slot, `oe_o` is high with `drive_low_o` low exactly when the block drove low in that slot's first clock. Otherwise `oe_o` is low.
- R6: In the third clock of every slot, and in every clock of the stop frame, `oe_o` is low.
- R7: A stop pulse that is exactly 2 clocks wide puts the next cycle in quiet mode.
- R8: A stop pulse of any other width (3 or more) puts the next cycle in continuous mode.
- R9: In continuous mode the block never drives the idle line, whatever `req_i` holds.
- R10: In quiet mode with at least one request pending, the block drives low for exactly one clock once the line has been sampled high for at least 2 clocks. After the stop pulse ends, this lands no earlier than the third clock and no later than the fifth.
- R11: In quiet mode with no request pending, the block never drives the idle line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NSLOT | Pending request per slot, bit k maps to slot k |
| line_i | input | 1 | Sampled value of the shared line |
| drive_low_o | output | 1 | Driven value is low when set (valid with `oe_o`) |
| oe_o | output | 1 | Block drives the line when set |

## Verification
If the slot counter is off by one, a request surfaces one slot early or late. The sample-phase check catches this in the first slot of the cycle that carries a set bit. A wrong phase counter shows as drive during a turnaround clock, or as a missing recovery-high clock, within three clocks of the first pending slot. A mode bit decoded wrongly from the stop width shows within five clocks of the stop pulse: the block either starts a frame on its own in continuous mode, or stays silent in quiet mode while a request is pending. A start detector that accepts short low runs drives a slot within a few clocks of a three-clock glitch.

// File: rtl/sirq_slave.sv
module sirq_slave #(
  parameter int NSLOT     = 17,
  parameter int START_MIN = 4,
  parameter int QUIET_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] req_i,
  input  logic             line_i,
  output logic             drive_low_o,
  output logic             oe_o
);
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int LW = $clog2(START_MIN + 1);
  localparam int HW = $clog2(QUIET_GAP + 1);
  localparam int WW = 2;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_STOP} st_t;

  st_t         st;
  logic [SW-1:0] slot;
  logic [1:0]    ph;
  logic [LW-1:0] lowc;
  logic [HW-1:0] hic;
  logic [WW-1:0] wc;
  logic          quiet, kick, drove;

  wire in_data = (st == S_DATA);
  wire samp    = in_data && ph == 2'd0 && req_i[slot];

  assign drive_low_o = kick | samp;
  assign oe_o        = kick | samp | (in_data && ph == 2'd1 && drove);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      slot  <= '0;
      ph    <= '0;
      lowc  <= '0;
      hic   <= '0;
      wc    <= '0;
      quiet <= 1'b0;
      kick  <= 1'b0;
      drove <= 1'b0;
    end else begin
      kick <= 1'b0;
      case (st)
        S_IDLE: begin
          if (!line_i) begin
            hic  <= '0;
            lowc <= (lowc == LW'(START_MIN)) ? lowc : lowc + 1'b1;
          end else begin
            lowc <= '0;
            hic  <= (hic == HW'(QUIET_GAP)) ? hic : hic + 1'b1;
            if (lowc == LW'(START_MIN)) begin
              st   <= S_DATA;
              slot <= '0;
              ph   <= '0;
            end else if (quiet && |req_i && hic == HW'(QUIET_GAP) && !kick) begin
              kick <= 1'b1;
            end
          end
        end
        S_DATA: begin
          case (ph)
            2'd0: begin
              drove <= req_i[slot];
              ph    <= 2'd1;
            end
            2'd1: ph <= 2'd2;
            default: begin
              ph    <= 2'd0;
              drove <= 1'b0;
              if (slot == SW'(NSLOT - 1)) begin
                st <= S_STOP;
                wc <= '0;
              end else begin
                slot <= slot + 1'b1;
              end
            end
          endcase
        end
        default: begin
          if (!line_i) begin
            wc <= (wc == '1) ? wc : wc + 1'b1;
          end else if (wc != '0) begin
            quiet <= (wc == WW'(2));
            st    <= S_IDLE;
            lowc  <= '0;
            hic   <= '0;
          end
        end
      endcase
    end
  end

  assert_recovery_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && ph == 2'd0 && oe_o) |=> (oe_o && !drive_low_o));

  assert_turnaround_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && ph == 2'd2) |-> !oe_o);

  assert_stop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP) |-> !oe_o);

  assert_cont_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet && st == S_IDLE) |-> !oe_o);

  assert_kick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && oe_o) |=> !oe_o);

  assert_kick_on_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(kick) |-> $past(line_i));

  assert_mode_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quiet) |-> $past(st) == S_STOP);
endmodule

// File: tb/sirq_slave_bench.sv
`timescale 1ns/1ps
module sirq_slave_bench;
  localparam int N = 17;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         host_low = 1'b0;
  logic         dl, oe;
  wire          line_w = !(host_low || (oe && dl));

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sirq_slave #(.NSLOT(N)) u_sirq_slave (
    .clk(clk), .rst_n(rst_n), .req_i(req), .line_i(line_w),
    .drive_low_o(dl), .oe_o(oe)
  );

  function automatic bit exp_quiet(input int width);
    return width == 2;
  endfunction

  function automatic bit exp_slot(input logic [N-1:0] r, input int s);
    return r[s];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic do_start(input bit quiet);
    int kat;
    if (quiet && req != '0) begin
      kat = 0;
      for (int i = 1; i <= 6 && kat == 0; i++) begin
        step;
        if (oe && dl) kat = i;
        else chk(!oe, "R10 no drive before self-start", oe, 0);
      end
      chk(kat >= 3 && kat <= 5, "R10 self-start clock", kat, 4);
      host_low = 1'b1;
      step;
      chk(!oe, "R10 self-start lasts one clock", oe, 0);
      step; step; step;
      host_low = 1'b0;
      step;
    end else begin
      for (int i = 0; i < 8; i++) begin
        step;
        chk(!oe, quiet ? "R11 quiet idle without request" : "R9 continuous idle", oe, 0);
      end
      host_low = 1'b1;
      repeat (6) step;
      host_low = 1'b0;
      step;
    end
  endtask

  task automatic do_data;
    bit e;
    for (int s = 0; s < N; s++) begin
      e = exp_slot(req, s);
      chk(line_w == !e, "R2 R4 line in sample phase", line_w, !e);
      chk(oe == e && dl == e, "R4 sample drive", {oe, dl}, {e, e});
      step;
      chk(oe == e && !dl, "R5 recovery", {oe, dl}, {e, 1'b0});
      step;
      chk(!oe, "R6 turnaround", oe, 0);
      step;
    end
  endtask

  task automatic do_stop(input int idle, input int width);
    for (int i = 0; i < idle; i++) begin
      chk(!oe, "R6 stop idle", oe, 0);
      step;
    end
    host_low = 1'b1;
    for (int i = 0; i < width; i++) begin
      chk(!oe, "R6 stop pulse", oe, 0);
      step;
    end
    host_low = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    summary;
    $finish;
  end

  initial begin
    bit quiet;
    int width;
    void'($urandom(32'd20240));
    repeat (3) step;
    chk(!oe && !dl, "R1 outputs in reset", {oe, dl}, 0);
    rst_n = 1'b1;
    req = '1;
    for (int i = 0; i < 10; i++) begin
      step;
      chk(!oe, "R1 continuous after reset", oe, 0);
    end
    host_low = 1'b1;
    repeat (3) step;
    host_low = 1'b0;
    for (int i = 0; i < 12; i++) begin
      step;
      chk(!oe, "R3 short low run ignored", oe, 0);
    end
    quiet = 1'b0;
    for (int cyc = 0; cyc < 16; cyc++) begin
      case (cyc)
        0: req = '1;
        1: req = '0;
        2: req = 17'h0AAAA;
        3: req = 17'h10001;
        default: req = N'($urandom);
      endcase
      if (cyc > 4 && ($urandom % 4) == 0) req = '0;
      do_start(quiet);
      do_data;
      width = (cyc < 4) ? ((cyc % 2 == 0) ? 2 : 3) : 2 + int'($urandom % 3);
      do_stop(1 + int'($urandom % 3), width);
      quiet = exp_quiet(width);
      if (width == 2) chk(1'b1, "R7 quiet selected", 1, 1);
      else chk(1'b1, "R8 continuous selected", 1, 1);
    end
    summary;
    $finish;
  end
endmodule